// File: doc/BRIEF.md
# Autonomous Fuse Word Read Sequencer

This block reads one 32-bit word out of a small one-time-programmable fuse array without software driving any select or strobe pins. Software makes a single write to a command register. That write carries an enable bit, a read-request bit and a word address. A hardware state machine then selects the array, holds its strobe for a set number of clocks, and captures the word into a data-out register. When it finishes, it raises a completion flag. The flag also drives a level interrupt, and software clears it by writing one to it.

The array model holds 128 bytes, which is 32 words. The first 96 bytes (words 0 to 23) are a secure region. The last 32 bytes (words 24 to 31) are open to every requester. A non-secure requester that asks for a secure word receives zero data, and the completion flag still sets. The default strobe width keeps every read far inside the 4 µs budget that software allows, which is 200 cycles at 50 MHz.

Top module: `fuse_autoread`

## Requirements
- R1: After reset, the status register (0x18), the data-out register (0x20), the command register (0x24) and `irq` all read zero.
- R2: A read starts only when a single idle write to 0x24 sets both bit 0 (enable) and bit 1 (read request). Any idle write to 0x24 stores the enable bit into readback bit 0 and the word address from bits [25:16] into readback bits [25:16]. A write that does not set both bits starts nothing.
- R3: With a strobe width of S cycles, the completion flag (0x18 bit 0) and the new data-out value appear S+2 clock edges after the edge that accepts the command. Readback bit 1 of 0x24 reads 1 from acceptance until the sequence returns to idle, one edge after the flag sets.
- R4: Word N returns bytes 4N to 4N+3 in little-endian order: byte 4N sits in bits [7:0]. The model's byte k holds (29·k + 91) mod 256.
- R5: The `bus_secure` level is sampled with the command. A non-secure command for words 0–23 returns zero data and still sets the flag. Words 24–31 return their contents to any requester. Secure requesters read every word.
- R6: A word address of 32 or more returns zero data and sets the flag.
- R7: Writes to 0x24 while a read is in progress are ignored. The stored address and the returned data stay those of the running command, and no second read follows.
- R8: Writing 1 to bit 0 of 0x18 clears the flag. Writing 0 leaves it set.
- R9: `irq` equals the completion flag at all times.
- R10: Every read completes within 200 clock cycles of acceptance.
- R11: Data-out changes only when a sequence captures. Flag clears and non-starting writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address for both writes and reads |
| bus_wdata | input | 32 | Write data |
| bus_secure | input | 1 | 1 when the current writer is a secure requester |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt, high while the completion flag is set |

## Verification
Counting from the accepting edge, the results arrive at fixed points. The busy readback is due one edge later. The flag, `irq` and data-out are all due S+2 edges later, and the return to idle comes one edge after that. Each read scenario samples on the falling edge just before edge S+2, where it expects the flag low and busy high. It samples again on the falling edge just after that edge, where it expects the flag, `irq` and the data. For the ignored-write and non-start cases, the bench waits well past S+2 edges and then reads the flag, the command readback and data-out to confirm that nothing moved.

// File: rtl/fuse_autoread.sv
module fuse_autoread #(
  parameter int WORDS        = 32,
  parameter int SECURE_WORDS = 24,
  parameter int WADDR_W      = 10,
  parameter int STROBE_CYC   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_secure,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam logic [7:0] A_STAT = 8'h18;
  localparam logic [7:0] A_DOUT = 8'h20;
  localparam logic [7:0] A_CTRL = 8'h24;
  localparam int CNT_W = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_CYC - 1);

  localparam logic [2:0] S_IDLE = 3'd0, S_SEL = 3'd1, S_STRB = 3'd2,
                         S_CAP  = 3'd3, S_DONE = 3'd4;

  logic [2:0]         state;
  logic [CNT_W-1:0]   cnt;
  logic [WADDR_W-1:0] addr_q;
  logic               en_q, sec_q, done_q;
  logic [31:0]        arr_q, dout_q;

  function automatic logic [31:0] fuse_word(input logic [WADDR_W-1:0] w);
    logic [31:0] r;
    r = '0;
    if (int'(w) < WORDS)
      for (int i = 0; i < 4; i++)
        r[i*8 +: 8] = 8'((int'(w) * 4 + i) * 29 + 91);
    return r;
  endfunction

  wire wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  wire wr_stat = bus_wr && (bus_addr == A_STAT);
  wire busy    = (state != S_IDLE);
  wire strobe  = (state == S_STRB);
  wire deny    = !sec_q && (addr_q < WADDR_W'(SECURE_WORDS));
  wire unused_ok = &{1'b0, bus_wdata[31:26], bus_wdata[15:2]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: if (wr_ctrl && bus_wdata[1:0] == 2'b11) state <= S_SEL;
        S_SEL: begin
          state <= S_STRB;
          cnt   <= '0;
        end
        S_STRB: if (cnt == CNT_LAST) state <= S_CAP;
                else cnt <= cnt + 1'b1;
        S_CAP:  state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q   <= 1'b0;
      addr_q <= '0;
      sec_q  <= 1'b0;
    end else if (!busy && wr_ctrl) begin
      en_q   <= bus_wdata[0];
      addr_q <= bus_wdata[16 +: WADDR_W];
      sec_q  <= bus_secure;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      arr_q <= '0;
    else if (strobe) arr_q <= fuse_word(addr_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 dout_q <= '0;
    else if (state == S_CAP)    dout_q <= deny ? '0 : arr_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                       done_q <= 1'b0;
    else if (state == S_CAP)          done_q <= 1'b1;
    else if (wr_stat && bus_wdata[0]) done_q <= 1'b0;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_STAT: bus_rdata = {31'b0, done_q};
      A_DOUT: bus_rdata = dout_q;
      A_CTRL: begin
        bus_rdata[16 +: WADDR_W] = addr_q;
        bus_rdata[1] = busy;
        bus_rdata[0] = en_q;
      end
      default: bus_rdata = '0;
    endcase
  end

  assign irq = done_q;
endmodule

// File: rtl/fuse_autoread_chk.sv
module fuse_autoread_chk #(
  parameter int SECURE_WORDS = 24,
  parameter int WADDR_W      = 10,
  parameter int LIMIT_CYC    = 200
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2:0]         st,
  input logic [WADDR_W-1:0] addr,
  input logic               sec,
  input logic [31:0]        dout,
  input logic               irq,
  input logic               bus_wr,
  input logic [7:0]         bus_addr,
  input logic               bus_wdata0
);
  localparam logic [2:0] C_IDLE = 3'd0, C_CAP = 3'd3;
  logic [15:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            run_cnt <= '0;
    else if (st == C_IDLE) run_cnt <= '0;
    else                   run_cnt <= run_cnt + 1'b1;

  always_ff @(posedge clk)
    if (rst_n) assert_read_in_budget_R10: assert (run_cnt < 16'(LIMIT_CYC));

  assert_capture_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_CAP) |=> irq);

  assert_irq_rises_from_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(st) == C_CAP));

  assert_dout_only_on_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> ($past(st) == C_CAP));

  assert_busy_keeps_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st != C_IDLE) |=> $stable(addr));

  assert_secure_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_CAP && !sec && addr < WADDR_W'(SECURE_WORDS)) |=> (dout == 32'h0));

  assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h18 && bus_wdata0 && st != C_CAP) |=> !irq);
endmodule

bind fuse_autoread fuse_autoread_chk #(
  .SECURE_WORDS(SECURE_WORDS), .WADDR_W(WADDR_W), .LIMIT_CYC(200)
) u_chk (
  .clk(clk), .rst_n(rst_n), .st(state), .addr(addr_q), .sec(sec_q),
  .dout(dout_q), .irq(irq), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata0(bus_wdata[0])
);

// File: tb/sim_fuse_autoread.sv
module sim_fuse_autoread;
  localparam int S = 4;
  logic clk = 0, rst_n = 0, bus_wr = 0, bus_secure = 0, irq;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  int checks = 0, errors = 0;

  fuse_autoread #(.STROBE_CYC(S)) u0 (.*);

  always #10 clk = ~clk;

  function automatic logic [31:0] exp_word(input int n);
    logic [31:0] r = '0;
    if (n < 32)
      for (int b = 0; b < 4; b++) r[b*8 +: 8] = 8'(((4*n + b) * 29 + 91) % 256);
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic sec);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d; bus_secure = sec;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 0; bus_secure = 0;
  endtask

  task automatic clear_flag();
    logic [31:0] d;
    wr(8'h18, 32'h1, 0);
    rd(8'h18, d); check("R8 clear", d, 0);
    check("R9 irq low", {31'b0, irq}, 0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h18, d); check("R1 status", d, 0);
    rd(8'h20, d); check("R1 dout", d, 0);
    rd(8'h24, d); check("R1 ctrl", d, 0);
    check("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_read(input string tag, input int w, input logic sec, input logic [31:0] exp);
    logic [31:0] d;
    wr(8'h24, (32'(w) << 16) | 32'h3, sec);
    repeat (S + 1) @(posedge clk);
    @(negedge clk);
    rd(8'h18, d); check("R3 flag not early", d, 0);
    rd(8'h24, d); check("R3 busy", {31'b0, d[1]}, 1);
    @(posedge clk);
    @(negedge clk);
    rd(8'h18, d); check("R3 flag on time", d, 1);
    check("R9 irq high", {31'b0, irq}, 1);
    rd(8'h20, d); check(tag, d, exp);
    @(posedge clk);
    @(negedge clk);
    rd(8'h24, d); check("R3 idle", {31'b0, d[1]}, 0);
    clear_flag();
  endtask

  task automatic t_no_start();
    logic [31:0] d;
    wr(8'h24, (32'd7 << 16) | 32'h1, 1);
    repeat (3 * S) @(posedge clk);
    @(negedge clk);
    rd(8'h18, d); check("R2 enable only: no flag", d, 0);
    rd(8'h24, d); check("R2 ctrl readback", d, (32'd7 << 16) | 32'h1);
    wr(8'h24, (32'd9 << 16) | 32'h2, 1);
    repeat (3 * S) @(posedge clk);
    @(negedge clk);
    rd(8'h18, d); check("R2 request only: no flag", d, 0);
    rd(8'h24, d); check("R2 ctrl readback 2", d, 32'd9 << 16);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] d;
    wr(8'h24, (32'd25 << 16) | 32'h3, 1);
    wr(8'h24, (32'd26 << 16) | 32'h3, 1);
    rd(8'h24, d); check("R7 addr kept", 32'(d[25:16]), 25);
    repeat (S + 2) @(posedge clk);
    @(negedge clk);
    rd(8'h20, d); check("R7 data of first command", d, exp_word(25));
    wr(8'h18, 32'h1, 0);
    repeat (3 * S) @(posedge clk);
    @(negedge clk);
    rd(8'h18, d); check("R7 no second read", d, 0);
  endtask

  task automatic t_w1c_hold();
    logic [31:0] d;
    t_read("R4 word 10", 10, 1, exp_word(10));
    wr(8'h24, (32'd11 << 16) | 32'h3, 1);
    repeat (S + 3) @(posedge clk);
    @(negedge clk);
    wr(8'h18, 32'h0, 0);
    rd(8'h18, d); check("R8 write zero keeps flag", d, 1);
    check("R9 irq stays", {31'b0, irq}, 1);
    clear_flag();
    rd(8'h20, d); check("R11 dout held after clear", d, exp_word(11));
    wr(8'h24, (32'd3 << 16) | 32'h1, 1);
    repeat (2 * S) @(posedge clk);
    @(negedge clk);
    rd(8'h20, d); check("R11 dout held after non-start", d, exp_word(11));
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL R10: watchdog expired, actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_read("R4 word 0 secure", 0, 1, exp_word(0));
    t_read("R4 word 31 secure", 31, 1, exp_word(31));
    t_read("R5 secure word 23 to secure", 23, 1, exp_word(23));
    t_read("R5 open word 24 non-secure", 24, 0, exp_word(24));
    t_read("R5 secure word 5 non-secure masked", 5, 0, 32'h0);
    t_read("R5 secure word 23 non-secure masked", 23, 0, 32'h0);
    t_read("R6 word 40 out of range", 40, 1, 32'h0);
    t_read("R6 word 1023 out of range", 1023, 0, 32'h0);
    t_no_start();
    t_busy_ignore();
    t_w1c_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule